// File: doc/BRIEF.md
# Serial P-Bit Network Update Scheduler

This block sequences the updates of a small network of probabilistic bits. Only one bit changes in any update slot. Slots visit the bits in ascending index order and wrap back to bit 0 after the last bit. For each slot that is not clamped, the scheduler does three things in turn. It asks an external local-field unit for a probability code, giving it the bit index and the current network state. It then strobes the addressed bit with that code and takes back the bit's new value. Last, it presents the whole network state as one sample on a valid/ready stream. As a result, one full sweep produces one sample per bit, not one sample per sweep.

A run begins with a start pulse. The pulse loads the initial state, latches the clamp mask and the sample target, and resets the slot index to bit 0. A clamped bit is loaded with its clamp value and keeps it for the whole run. Its slot makes no field request and no strobe, but it still produces a sample. The run ends after exactly the programmed number of samples. A done flag then rises and stays high until the next start.

Top module: `pbit_sweep_sched`

## Requirements
- R1: After reset, `fld_req`, `upd_stb`, `smp_valid` and `done` are all low, and they stay low until a start pulse.
- R2: A start pulse accepted while idle or done loads every bit i with `clamp_val[i]` when `clamp_mask[i]` is 1, and with `init_state[i]` otherwise. The first slot of the run addresses bit 0.
- R3: While a run is active, exactly one of `fld_req`, `upd_stb` and `smp_valid` is high in every cycle. Slots address bits 0,1,...,N-1,0,... in that order, one bit per slot.
- R4: In an unclamped slot, `fld_req` is raised with `fld_idx` equal to the slot index and `fld_state` equal to the current state. These are held until `fld_ack`, and `fld_code` is captured in the cycle of `fld_ack`.
- R5: After the field acknowledge, `upd_stb` is raised with `upd_idx` equal to the slot index and `upd_code` equal to the captured code. It is held until `upd_ack`, and `upd_bit` is then written into that bit only.
- R6: Every slot ends with `smp_valid` carrying `smp_idx` equal to the slot index and `smp_data` equal to the full state, including the bit just updated.
- R7: A slot whose bit is clamped issues no field request and no strobe, and its sample shows the clamp value. Changes to `clamp_mask` and `clamp_val` after the start pulse have no effect on the run.
- R8: While `smp_valid` is high and `smp_ready` is low, the sample holds stable and no new request is issued.
- R9: A run emits exactly `sample_target` samples and then raises `done`. `done` stays high with no activity until the next start. A target of 0 raises `done` with no samples.
- R10: A start pulse during an active run is ignored.
- R11: The sample counter spans 20 bits, so a run of 100,000 samples completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run start pulse |
| sample_target | input | 20 | Number of samples for the run, latched at start |
| init_state | input | 9 | Initial network state, loaded at start |
| clamp_mask | input | 9 | Per-bit clamp enable, latched at start |
| clamp_val | input | 9 | Per-bit clamp value, loaded at start |
| fld_req | output | 1 | Request to the local-field unit |
| fld_idx | output | 4 | Bit index of the request |
| fld_state | output | 9 | Current network state for the field computation |
| fld_ack | input | 1 | Field unit acknowledge |
| fld_code | input | 5 | Probability code returned with the acknowledge |
| upd_stb | output | 1 | Update strobe to the addressed bit |
| upd_idx | output | 4 | Bit index of the strobe |
| upd_code | output | 5 | Probability code applied to the bit |
| upd_ack | input | 1 | Bit update acknowledge |
| upd_bit | input | 1 | New value of the addressed bit |
| smp_valid | output | 1 | Sample valid |
| smp_ready | input | 1 | Sample ready |
| smp_data | output | 9 | Full network state sample |
| smp_idx | output | 4 | Index of the bit updated in this slot |
| done | output | 1 | Run complete |

## Verification
The assertions check, on every cycle, the handshake rules of the block. These are the single active phase, the holding of request, strobe and sample under stall, the transfer of the captured code into the strobe, a sample after every update, the next slot index after each accepted sample, and a quiet interface while done. The state contents are left to the bench. It tracks the merged initial state, which bit each acknowledge writes, and the clamped bits that must never be requested. It also covers the sample count for each run, start pulses ignored in mid-run, clamp inputs changed after start, a zero target, and a 100,000-sample run.

// File: rtl/psw_pkg.sv
// Package: shared types for the serial p-bit update scheduler.
// Assumes: one scheduler phase is active at a time.
package psw_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_REQ  = 3'd1,
        PH_UPD  = 3'd2,
        PH_EMIT = 3'd3,
        PH_DONE = 3'd4
    } phase_t;
endpackage

// File: rtl/psw_ring.sv
// Module: slot index ring and sample counter.
// Loads on start, advances once per accepted sample, and flags when the
// current sample is the last one of the run.
// Assumes: adv and load are never high in the same cycle.
module psw_ring #(
    parameter int N_BITS = 9,
    parameter int CNT_W  = 20,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] target_in,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nxt_idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_BITS - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tgt;

    // Next slot index with wrap after the top bit.
    always_comb begin
        nxt_idx = (idx == TOP_IDX) ? '0 : idx + 1'b1;
    end

    // The sample being emitted is the last when count+1 reaches the target.
    always_comb begin
        last = (({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) == {1'b0, tgt});
    end

    // Index, count and latched target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            cnt <= '0;
            tgt <= '0;
        end else if (load) begin
            idx <= '0;
            cnt <= '0;
            tgt <= target_in;
        end else if (adv) begin
            idx <= nxt_idx;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/psw_state.sv
// Module: network state register with per-bit clamp.
// Each bit loads its clamp value or initial value at start. Afterwards it is
// written only by an update addressed to it, and never while clamped.
// Assumes: wr_idx is below N_BITS whenever wr is high.
module psw_state #(
    parameter int N_BITS = 9,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [N_BITS-1:0] init_in,
    input  logic [N_BITS-1:0] mask_in,
    input  logic [N_BITS-1:0] val_in,
    input  logic              wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    output logic [N_BITS-1:0] state,
    output logic [N_BITS-1:0] mask
);
    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        // One p-bit cell: start load, clamp hold, addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state[i] <= 1'b0;
                mask[i]  <= 1'b0;
            end else if (load) begin
                mask[i]  <= mask_in[i];
                state[i] <= mask_in[i] ? val_in[i] : init_in[i];
            end else if (wr && (wr_idx == IDX_W'(i)) && !mask[i]) begin
                state[i] <= wr_bit;
            end
        end
    end
endmodule

// File: rtl/psw_fsm.sv
// Module: slot phase controller.
// Steps each slot through request, strobe and sample, and skips the first two
// phases for clamped bits. Captures the field code on acknowledge.
// Assumes: last and nxt_clamped describe the slot being emitted.
module psw_fsm #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tgt_zero,
    input  logic              first_clamped,
    input  logic              nxt_clamped,
    input  logic              last,
    input  logic              fld_ack,
    input  logic [CODE_W-1:0] fld_code,
    input  logic              upd_ack,
    input  logic              smp_ready,
    output psw_pkg::phase_t   phase,
    output logic              load,
    output logic              adv,
    output logic              wr,
    output logic [CODE_W-1:0] code
);
    import psw_pkg::*;

    phase_t nph;

    // Next-phase and strobe decode.
    always_comb begin
        nph  = phase;
        load = 1'b0;
        adv  = 1'b0;
        wr   = 1'b0;
        case (phase)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    load = 1'b1;
                    if (tgt_zero)           nph = PH_DONE;
                    else if (first_clamped) nph = PH_EMIT;
                    else                    nph = PH_REQ;
                end
            end
            PH_REQ: begin
                if (fld_ack) nph = PH_UPD;
            end
            PH_UPD: begin
                if (upd_ack) begin
                    wr  = 1'b1;
                    nph = PH_EMIT;
                end
            end
            PH_EMIT: begin
                if (smp_ready) begin
                    adv = 1'b1;
                    if (last)             nph = PH_DONE;
                    else if (nxt_clamped) nph = PH_EMIT;
                    else                  nph = PH_REQ;
                end
            end
            default: nph = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nph;
    end

    // Probability code capture on field acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                          code <= '0;
        else if (phase == PH_REQ && fld_ack) code <= fld_code;
    end
endmodule

// File: rtl/pbit_sweep_sched.sv
// Module: serial update scheduler for a p-bit network (top).
// Updates one bit per slot in ascending round-robin order, and emits the full
// state after every slot on a valid/ready stream.
// Assumes: the field unit and the bits answer through req/ack handshakes.
module pbit_sweep_sched #(
    parameter int N_BITS = 9,
    parameter int CODE_W = 5,
    parameter int CNT_W  = 20,
    parameter int IDX_W  = $clog2(N_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  sample_target,
    input  logic [N_BITS-1:0] init_state,
    input  logic [N_BITS-1:0] clamp_mask,
    input  logic [N_BITS-1:0] clamp_val,
    output logic              fld_req,
    output logic [IDX_W-1:0]  fld_idx,
    output logic [N_BITS-1:0] fld_state,
    input  logic              fld_ack,
    input  logic [CODE_W-1:0] fld_code,
    output logic              upd_stb,
    output logic [IDX_W-1:0]  upd_idx,
    output logic [CODE_W-1:0] upd_code,
    input  logic              upd_ack,
    input  logic              upd_bit,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [N_BITS-1:0] smp_data,
    output logic [IDX_W-1:0]  smp_idx,
    output logic              done
);
    import psw_pkg::*;

    phase_t            phase;
    logic              load, adv, wr, last;
    logic [IDX_W-1:0]  idx, nxt_idx;
    logic [N_BITS-1:0] state, mask;
    logic [CODE_W-1:0] code;

    psw_ring #(.N_BITS(N_BITS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .load(load), .target_in(sample_target),
        .adv(adv), .idx(idx), .nxt_idx(nxt_idx), .last(last)
    );

    psw_state #(.N_BITS(N_BITS), .IDX_W(IDX_W)) u_state (
        .clk(clk), .rst_n(rst_n), .load(load), .init_in(init_state),
        .mask_in(clamp_mask), .val_in(clamp_val), .wr(wr), .wr_idx(idx),
        .wr_bit(upd_bit), .state(state), .mask(mask)
    );

    psw_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tgt_zero(sample_target == '0), .first_clamped(clamp_mask[0]),
        .nxt_clamped(mask[nxt_idx]), .last(last),
        .fld_ack(fld_ack), .fld_code(fld_code), .upd_ack(upd_ack),
        .smp_ready(smp_ready), .phase(phase), .load(load), .adv(adv),
        .wr(wr), .code(code)
    );

    // Output decode: the phase selects which handshake is active.
    always_comb begin
        fld_req   = (phase == PH_REQ);
        upd_stb   = (phase == PH_UPD);
        smp_valid = (phase == PH_EMIT);
        done      = (phase == PH_DONE);
        fld_idx   = idx;
        upd_idx   = idx;
        smp_idx   = idx;
        fld_state = state;
        smp_data  = state;
        upd_code  = code;
    end
endmodule

// File: rtl/pbit_sweep_sched_chk.sv
// Module: protocol checker for pbit_sweep_sched, bound to the top.
// Assumes: synchronous active-low reset shared with the design.
module pbit_sweep_sched_chk #(
    parameter int N_BITS = 9,
    parameter int CODE_W = 5,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fld_req,
    input logic [IDX_W-1:0]  fld_idx,
    input logic [N_BITS-1:0] fld_state,
    input logic              fld_ack,
    input logic [CODE_W-1:0] fld_code,
    input logic              upd_stb,
    input logic [IDX_W-1:0]  upd_idx,
    input logic [CODE_W-1:0] upd_code,
    input logic              upd_ack,
    input logic              smp_valid,
    input logic              smp_ready,
    input logic [N_BITS-1:0] smp_data,
    input logic [IDX_W-1:0]  smp_idx,
    input logic              done
);
    logic [IDX_W-1:0] exp_nxt;

    // Expected slot index after the current sample.
    always_comb begin
        exp_nxt = (smp_idx == IDX_W'(N_BITS - 1)) ? '0 : smp_idx + 1'b1;
    end

    a_r3_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fld_req, upd_stb, smp_valid, done}));

    a_r3_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> done
            || (fld_req && fld_idx == $past(exp_nxt))
            || (smp_valid && smp_idx == $past(exp_nxt)));

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_req && !fld_ack) |=> (fld_req && $stable(fld_idx) && $stable(fld_state)));

    a_r5_code_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_req && fld_ack) |=> (upd_stb && upd_code == $past(fld_code)
                                  && upd_idx == $past(fld_idx)));

    a_r5_stb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !upd_ack) |=> (upd_stb && $stable(upd_idx) && $stable(upd_code)));

    a_r6_sample_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && upd_ack) |=> (smp_valid && smp_idx == $past(upd_idx)));

    a_r8_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_idx)));

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!fld_req && !upd_stb && !smp_valid));
endmodule

bind pbit_sweep_sched pbit_sweep_sched_chk #(
    .N_BITS(N_BITS), .CODE_W(CODE_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fld_req(fld_req), .fld_idx(fld_idx),
    .fld_state(fld_state), .fld_ack(fld_ack), .fld_code(fld_code),
    .upd_stb(upd_stb), .upd_idx(upd_idx), .upd_code(upd_code),
    .upd_ack(upd_ack), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_idx(smp_idx), .done(done)
);

// File: tb/sim_pbit_sweep_sched.sv
// Bench: behavioural reference model of the scheduler, compared on every
// falling edge; stimulus and responders are driven away from the rising edge.
module sim_pbit_sweep_sched;
    localparam int CLK_PERIOD = 10;
    localparam int N = 9;
    localparam int CW = 5;
    localparam int TW = 20;
    localparam int IW = 4;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [TW-1:0] sample_target = '0;
    logic [N-1:0] init_state = '0, clamp_mask = '0, clamp_val = '0;
    logic fld_req, upd_stb, smp_valid, done;
    logic [IW-1:0] fld_idx, upd_idx, smp_idx;
    logic [N-1:0] fld_state, smp_data;
    logic [CW-1:0] upd_code;
    logic fld_ack = 1'b0, upd_ack = 1'b0, upd_bit = 1'b0, smp_ready = 1'b0;
    logic [CW-1:0] fld_code = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int p_ack = 100;
    int p_rdy = 100;
    int samples = 0;

    // Reference model state.
    bit       m_busy = 0;
    bit       m_done = 0;
    int       m_ph = 0;     // 0 request due, 1 strobe due, 2 sample due
    int       m_idx = 0;
    int       m_cnt = 0;
    int       m_tgt = 0;
    bit [N-1:0] m_state = '0;
    bit [N-1:0] m_mask = '0;
    bit [CW-1:0] m_code = '0;

    pbit_sweep_sched u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sample_target(sample_target),
        .init_state(init_state), .clamp_mask(clamp_mask), .clamp_val(clamp_val),
        .fld_req(fld_req), .fld_idx(fld_idx), .fld_state(fld_state),
        .fld_ack(fld_ack), .fld_code(fld_code), .upd_stb(upd_stb),
        .upd_idx(upd_idx), .upd_code(upd_code), .upd_ack(upd_ack),
        .upd_bit(upd_bit), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_data(smp_data), .smp_idx(smp_idx), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic bit roll(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    // Watchdog: an overrun counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Per-cycle comparison against the model, then responder drive.
    always @(negedge clk) begin
        if (!rst_n) begin
            check("R1 reset quiet", {fld_req, upd_stb, smp_valid, done}, 4'b0000);
        end else begin
            check(m_busy ? "R3 one phase active" : "R1/R9 quiet when not running",
                  32'(fld_req) + 32'(upd_stb) + 32'(smp_valid), m_busy ? 1 : 0);
            check("R9 done flag", done, m_done);
            if (fld_req) begin
                check("R3/R7 request allowed only in request phase", m_ph, 0);
                check("R3 request index", fld_idx, m_idx);
                check("R2/R4 request state", fld_state, m_state);
            end
            if (upd_stb) begin
                check("R5 strobe phase", m_ph, 1);
                check("R5 strobe index", upd_idx, m_idx);
                check("R5 strobe code", upd_code, m_code);
            end
            if (smp_valid) begin
                check("R6 sample phase", m_ph, 2);
                check("R6 sample index", smp_idx, m_idx);
                check("R6/R7 sample data", smp_data, m_state);
            end
            // R10: the model takes a start only when not busy.
            if (start && !m_busy) begin
                m_mask  = clamp_mask;
                m_state = (clamp_mask & clamp_val) | (~clamp_mask & init_state);
                m_idx = 0;
                m_cnt = 0;
                m_tgt = int'(sample_target);
                samples = 0;
                if (m_tgt == 0) begin
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    m_busy = 1;
                    m_done = 0;
                    m_ph = m_mask[0] ? 2 : 0;
                end
            end
            fld_code = CW'($urandom);
            fld_ack = fld_req && roll(p_ack);
            if (fld_ack) begin
                m_code = fld_code;
                m_ph = 1;
            end
            upd_bit = 1'($urandom);
            upd_ack = upd_stb && roll(p_ack);
            if (upd_ack) begin
                m_state[m_idx] = upd_bit;
                m_ph = 2;
            end
            smp_ready = roll(p_rdy);
            if (smp_valid && smp_ready) begin
                samples++;
                m_cnt++;
                if (m_cnt == m_tgt) begin
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    m_idx = (m_idx + 1) % N;
                    m_ph = m_mask[m_idx] ? 2 : 0;
                end
            end
        end
    end

    task automatic pulse_start;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done;
        while (!done) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);          // R1: idle with no start

        // R2 R3 R6: no clamps, three full sweeps, random handshake delays.
        p_ack = 60; p_rdy = 70;
        #1 init_state = 9'h1A5; clamp_mask = '0; sample_target = 27;
        pulse_start();
        wait_done();
        check("R9 sample count unclamped", samples, 27);

        // R7 R8: clamps with back-pressure; clamp inputs change after start.
        p_ack = 50; p_rdy = 30;
        #1 init_state = 9'h0F0; clamp_mask = 9'b101010101; clamp_val = 9'b100000001;
        sample_target = 40;
        pulse_start();
        #1 clamp_mask = 9'b010101010; clamp_val = 9'h1FF;   // R7: must be ignored
        wait_done();
        check("R7/R9 sample count clamped", samples, 40);

        // R10: start pulses in mid-run with other settings are ignored.
        p_ack = 80; p_rdy = 80;
        #1 init_state = 9'h03C; clamp_mask = 9'b000000001; clamp_val = '0;
        sample_target = 50;
        pulse_start();
        repeat (20) @(posedge clk);
        #1 init_state = 9'h1FF; sample_target = 3;
        pulse_start();
        wait_done();
        check("R10 count after ignored start", samples, 50);
        check("R9 done held", done, 1'b1);

        // R9: zero target gives done with no samples.
        #1 sample_target = 0;
        pulse_start();
        repeat (5) @(posedge clk);
        check("R9 zero target samples", samples, 0);
        check("R9 zero target done", done, 1'b1);

        // R11: 100,000 samples with every bit clamped and no stalls.
        p_ack = 100; p_rdy = 100;
        #1 clamp_mask = 9'h1FF; clamp_val = 9'h0B3; sample_target = 100000;
        pulse_start();
        wait_done();
        check("R11 long run count", samples, 100000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule